// File: doc/BRIEF.md
# Reset Generator with Cause Register

This block merges four reset requests into one system reset. The four requests are a power-on strobe, a low-voltage strobe, a clock-monitor failure strobe and an active-low external pin. Any active request drives the system reset high at once, with no clock edge needed. The reset falls again only after the system clock has made two rising edges with every request inactive.

A 16-bit status word records why the last reset happened. Each cause has a sticky flag that the host clears by writing a one. The word also holds the divider-select pin code, which is sampled only on the heavier reset kinds, and a clock-source select bit that the host can read and write. A write-only arm bit turns on the clock-monitor enable output, and every reset turns that output off again.

The cause flags and the sampled divider code live in flops that the external pin does not clear. After a pin reset, software can therefore still see an earlier power-on or low-voltage cause.

Top module: `rst_cause_gen`

## Requirements
- R1: While any request is active (por_i high, lvd_i high, cmf_i high or ext_rst_n low), sys_rst_o is high, and it rises without waiting for a clock edge.
- R2: Once the last request goes inactive, sys_rst_o stays high through the first rising clk edge and goes low at the second.
- R3: rd_data has this layout: bit 0 is the low-voltage flag, bit 1 the clock-monitor flag, bit 2 the power-on flag, bit 3 the external flag, bit 8 the clock-source select, bits 10:9 the divider code. Every other bit reads 0.
- R4: At each clock edge where requests are active, only the flag of the highest-priority active request is set. The order from highest to lowest is power-on, low-voltage, clock-monitor, external. A power-on clears the three other flags. A low-voltage request clears the clock-monitor and external flags.
- R5: A write with wr_en high clears each of bits 3:0 whose wr_data bit is 1. A 0 in those bits leaves the flag unchanged.
- R6: While the low-voltage flag or the power-on flag is 1, bits 1 and 3 of rd_data read 0. The stored flags behind them are kept.
- R7: div_sel_i is captured into bits 10:9 on a power-on, low-voltage or clock-monitor request. An external-pin request does not capture it.
- R8: Bit 8 is written from wr_data[8], drives clk_src_o (0 selects the main input clock, 1 the alternate clock) and is cleared at every clock edge during system reset.
- R9: Writing 1 to wr_data[7] sets cm_en_o. Bit 7 reads 0, and cm_en_o is cleared at every clock edge during system reset.
- R10: An external-pin reset clears neither the other flags nor the divider code.
- R11: When a request and a clearing write hit the same flag at the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on request, active high |
| lvd_i | input | 1 | Low-voltage request, active high |
| cmf_i | input | 1 | Clock-monitor failure request, active high |
| ext_rst_n | input | 1 | External reset pin, active low |
| div_sel_i | input | 2 | Divider-select pins |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Status word |
| sys_rst_o | output | 1 | System reset, active high |
| clk_src_o | output | 1 | Host-side clock source select |
| cm_en_o | output | 1 | Clock-monitor enable |

## Verification
The assertions are checked at every clock edge. They cover these rules: reset stays high while any request is present, and a falling reset always has a quiet request set one edge earlier. They also check that power-on and low-voltage events leave the correct flag pattern. A zero write or a pin-only reset leaves the stored flags and divider code unchanged. Reset turns off the clock-monitor enable and the clock-source bit, and the flags hidden by masking always read as 0.

Some behaviour can only be shown by the bench's scenarios:
- the rise of the reset between clock edges;
- the exact two-edge release;
- the full value of the status word after each kind of reset;
- a flag masked by power-on reappearing once power-on is cleared;
- a request winning over a clearing write in the same cycle.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    localparam int REG_W       = 16;
    localparam int DIV_W       = 2;
    localparam int SYNC_STAGES = 2;
    localparam int CAUSE_W     = 4;

    localparam int POS_LV      = 0;
    localparam int POS_CM      = 1;
    localparam int POS_PR      = 2;
    localparam int POS_EXT     = 3;
    localparam int POS_ARM     = 7;
    localparam int POS_SRC     = 8;
    localparam int POS_DIV_LO  = 9;
    localparam int POS_DIV_HI  = POS_DIV_LO + DIV_W - 1;

    // packed so that bit index equals register bit position
    typedef struct packed {
        logic ext;
        logic pr;
        logic cm;
        logic lv;
    } cause_t;

    typedef struct packed {
        logic por;
        logic lvd;
        logic cmf;
        logic pin;
    } req_t;

    function automatic logic any_req(req_t r);
        return r.por | r.lvd | r.cmf | r.pin;
    endfunction

    function automatic logic heavy_req(req_t r);
        return r.por | r.lvd | r.cmf;
    endfunction

    // flags seen by the host: the two weak flags are hidden under a strong one
    function automatic cause_t visible(cause_t c);
        cause_t v;
        v = c;
        if (c.lv || c.pr) begin
            v.cm  = 1'b0;
            v.ext = 1'b0;
        end
        return v;
    endfunction
endpackage

// File: rtl/rcg_sync.sv
module rcg_sync #(
    parameter int STAGES = rcg_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic raw_i,
    input  logic por_i,
    output logic rst_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge raw_i) begin
        if (raw_i) chain <= '1;
        else       chain <= {chain[STAGES-2:0], 1'b0};
    end

    assign rst_o = chain[STAGES-1];

    // R1: a present request is always seen as reset
    a_r1_req_holds_rst: assert property (@(posedge clk) raw_i |-> rst_o);

    // R2: release only after the request set was quiet on the prior edge
    a_r2_quiet_before_release: assert property (@(posedge clk) disable iff (por_i)
        $fell(rst_o) |-> !$past(raw_i));
endmodule

// File: rtl/rcg_cause.sv
module rcg_cause
    import rcg_pkg::*;
(
    input  logic               clk,
    input  req_t               req_i,
    input  logic               wr_en,
    input  logic [CAUSE_W-1:0] clr_i,
    input  logic [DIV_W-1:0]   div_sel_i,
    output cause_t             flags_o,
    output logic [DIV_W-1:0]   div_o
);
    cause_t flags_q, flags_d;
    logic [DIV_W-1:0] div_q;

    always_comb begin
        flags_d = flags_q & ~(wr_en ? cause_t'(clr_i) : cause_t'('0));
        if (req_i.por) begin
            flags_d    = '0;
            flags_d.pr = 1'b1;
        end else if (req_i.lvd) begin
            flags_d.lv  = 1'b1;
            flags_d.cm  = 1'b0;
            flags_d.ext = 1'b0;
        end else if (req_i.cmf) begin
            flags_d.cm = 1'b1;
        end else if (req_i.pin) begin
            flags_d.ext = 1'b1;
        end
    end

    // no reset term: these flops carry the cause across a pin reset
    always_ff @(posedge clk) begin
        flags_q <= flags_d;
        if (heavy_req(req_i)) div_q <= div_sel_i;
    end

    assign flags_o = flags_q;
    assign div_o   = div_q;

    // R4: power-on leaves only its own flag
    a_r4_por_alone: assert property (@(posedge clk) disable iff (1'b0)
        req_i.por |=> (flags_q == 4'b0100));

    // R4: low-voltage sets its flag and drops the weaker two
    a_r4_lv_drops_weak: assert property (@(posedge clk) disable iff (req_i.por)
        req_i.lvd |=> (flags_q.lv && !flags_q.cm && !flags_q.ext));

    // R5: a write of zeros with no request keeps every flag
    a_r5_zero_write: assert property (@(posedge clk) disable iff (req_i.por)
        (wr_en && clr_i == '0 && !any_req(req_i)) |=> $stable(flags_q));

    // R7 R10: a pin-only reset leaves the divider code alone
    a_r7_pin_keeps_div: assert property (@(posedge clk) disable iff (req_i.por)
        (req_i.pin && !heavy_req(req_i)) |=> $stable(div_q));
endmodule

// File: rtl/rcg_ctrl.sv
module rcg_ctrl (
    input  logic clk,
    input  logic sys_rst,
    input  logic por_i,
    input  logic wr_en,
    input  logic src_wr,
    input  logic arm_wr,
    output logic clk_src_o,
    output logic cm_en_o
);
    always_ff @(posedge clk) begin
        if (sys_rst) begin
            clk_src_o <= 1'b0;
            cm_en_o   <= 1'b0;
        end else if (wr_en) begin
            clk_src_o <= src_wr;
            if (arm_wr) cm_en_o <= 1'b1;
        end
    end

    // R9: reset always disarms the clock monitor
    a_r9_rst_disarms: assert property (@(posedge clk) disable iff (por_i)
        sys_rst |=> !cm_en_o);

    // R8: reset returns the host clock to the main input
    a_r8_rst_main_clk: assert property (@(posedge clk) disable iff (por_i)
        sys_rst |=> !clk_src_o);
endmodule

// File: rtl/rst_cause_gen.sv
module rst_cause_gen
    import rcg_pkg::*;
(
    input  logic              clk,
    input  logic              por_i,
    input  logic              lvd_i,
    input  logic              cmf_i,
    input  logic              ext_rst_n,
    input  logic [DIV_W-1:0]  div_sel_i,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              sys_rst_o,
    output logic              clk_src_o,
    output logic              cm_en_o
);
    req_t             req;
    cause_t           flags;
    cause_t           shown;
    logic [DIV_W-1:0] div_code;
    logic             unused_wr_bits;

    assign req.por = por_i;
    assign req.lvd = lvd_i;
    assign req.cmf = cmf_i;
    assign req.pin = ~ext_rst_n;

    assign unused_wr_bits = ^{wr_data[REG_W-1:POS_DIV_LO], wr_data[POS_ARM-1:CAUSE_W]};

    rcg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .raw_i (any_req(req)),
        .por_i (por_i),
        .rst_o (sys_rst_o)
    );

    rcg_cause u_cause (
        .clk       (clk),
        .req_i     (req),
        .wr_en     (wr_en),
        .clr_i     (wr_data[CAUSE_W-1:0]),
        .div_sel_i (div_sel_i),
        .flags_o   (flags),
        .div_o     (div_code)
    );

    rcg_ctrl u_ctrl (
        .clk       (clk),
        .sys_rst   (sys_rst_o),
        .por_i     (por_i),
        .wr_en     (wr_en),
        .src_wr    (wr_data[POS_SRC]),
        .arm_wr    (wr_data[POS_ARM]),
        .clk_src_o (clk_src_o),
        .cm_en_o   (cm_en_o)
    );

    assign shown = visible(flags);

    always_comb begin
        rd_data                         = '0;
        rd_data[CAUSE_W-1:0]            = shown;
        rd_data[POS_SRC]                = clk_src_o;
        rd_data[POS_DIV_HI:POS_DIV_LO]  = div_code;
    end

    // R6: a strong flag on the port never shows a weak one beside it
    a_r6_weak_hidden: assert property (@(posedge clk) disable iff (por_i)
        (rd_data[POS_LV] || rd_data[POS_PR]) |-> (!rd_data[POS_CM] && !rd_data[POS_EXT]));

    // R3 R9: unused and write-only bits read zero
    a_r3_spare_zero: assert property (@(posedge clk) disable iff (por_i)
        (rd_data[POS_ARM:CAUSE_W] == '0) && (rd_data[REG_W-1:POS_DIV_HI+1] == '0));
endmodule

// File: tb/sim_rst_cause_gen.sv
`timescale 1ns/1ps
module sim_rst_cause_gen;
    logic        clk = 1'b0;
    logic        por_i = 1'b1, lvd_i = 1'b0, cmf_i = 1'b0, ext_rst_n = 1'b1;
    logic [1:0]  div_sel_i = 2'b10;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        sys_rst_o, clk_src_o, cm_en_o;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    item_t cur;

    always #2.5 clk = ~clk;

    rst_cause_gen u0 (
        .clk(clk), .por_i(por_i), .lvd_i(lvd_i), .cmf_i(cmf_i), .ext_rst_n(ext_rst_n),
        .div_sel_i(div_sel_i), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sys_rst_o(sys_rst_o), .clk_src_o(clk_src_o), .cm_en_o(cm_en_o)
    );

    // monitor: compares the status word against queued expectations
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            tests++;
            if (rd_data !== cur.exp) begin
                fails++;
                $display("FAIL %s rd_data actual=%h expected=%h", cur.tag, rd_data, cur.exp);
            end
        end
    end

    task automatic expect_reg(input logic [15:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [15:0] v);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // power-on phase
        repeat (3) @(posedge clk);
        #1;
        chk(sys_rst_o, 1'b1, "R1 power-on holds reset");
        por_i = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(sys_rst_o, 1'b1, "R2 still high after first edge");
        @(posedge clk); @(negedge clk);
        chk(sys_rst_o, 1'b0, "R2 low after second edge");
        chk(clk_src_o, 1'b0, "R8 reset state clock source");
        chk(cm_en_o, 1'b0, "R9 reset state monitor off");
        expect_reg(16'h0404, "R3 R4 R7 after power-on");

        // pin reset between edges, new divider pins must not be taken
        div_sel_i = 2'b01;
        @(posedge clk); #1;
        ext_rst_n = 1'b0;
        #1;
        chk(sys_rst_o, 1'b1, "R1 pin reset rises without edge");
        @(posedge clk); #1;
        ext_rst_n = 1'b1;
        settle();
        chk(sys_rst_o, 1'b0, "R2 release after pin reset");
        expect_reg(16'h0404, "R6 R7 R10 pin flag hidden, divider kept");

        // clear power-on flag, pin flag shows
        host_write(16'h0004);
        expect_reg(16'h0408, "R5 R6 clear power-on flag");
        host_write(16'h0000);
        expect_reg(16'h0408, "R5 zero write keeps flags");

        // clock source and monitor arm
        host_write(16'h0100);
        chk(clk_src_o, 1'b1, "R8 clock source written");
        expect_reg(16'h0508, "R8 bit 8 reads back");
        host_write(16'h0180);
        chk(cm_en_o, 1'b1, "R9 monitor armed");
        expect_reg(16'h0508, "R9 arm bit reads zero");

        // clock-monitor failure, divider sampled
        div_sel_i = 2'b11;
        @(posedge clk); #1;
        cmf_i = 1'b1;
        @(posedge clk); #1;
        cmf_i = 1'b0;
        settle();
        chk(cm_en_o, 1'b0, "R9 monitor off after reset");
        chk(clk_src_o, 1'b0, "R8 main clock after reset");
        expect_reg(16'h060A, "R4 R7 clock-monitor cause");

        // low-voltage clears weak flags
        div_sel_i = 2'b00;
        @(posedge clk); #1;
        lvd_i = 1'b1;
        @(posedge clk); #1;
        lvd_i = 1'b0;
        settle();
        expect_reg(16'h0001, "R4 R7 low-voltage cause");

        // simultaneous low-voltage and pin: only low-voltage recorded
        host_write(16'h0001);
        expect_reg(16'h0000, "R5 clear low-voltage");
        @(posedge clk); #1;
        lvd_i = 1'b1; ext_rst_n = 1'b0;
        @(posedge clk); #1;
        lvd_i = 1'b0; ext_rst_n = 1'b1;
        settle();
        host_write(16'h0001);
        expect_reg(16'h0000, "R4 priority, pin flag not set");

        // request beats a clearing write on the same edge
        @(posedge clk); #1;
        ext_rst_n = 1'b0; wr_en = 1'b1; wr_data = 16'h0008;
        @(posedge clk); #1;
        ext_rst_n = 1'b1; wr_en = 1'b0; wr_data = '0;
        settle();
        expect_reg(16'h0008, "R11 set wins over clear");

        // pin reset with monitor armed
        host_write(16'h0080);
        chk(cm_en_o, 1'b1, "R9 armed again");
        div_sel_i = 2'b11;
        @(posedge clk); #1;
        ext_rst_n = 1'b0;
        @(posedge clk); #1;
        ext_rst_n = 1'b1;
        settle();
        chk(cm_en_o, 1'b0, "R9 pin reset disarms");
        expect_reg(16'h0008, "R7 R10 pin reset keeps divider and flags");

        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule